// File: doc/BRIEF.md
# Passive Cell-Bleed Channel Scheduler

This block decides which cells of a six-cell series stack get their bleed resistor switched on, and for how long. It compares the cell voltages against the lowest cell. It picks one or two eligible channels, either by round-robin rotation or by largest excess voltage, and keeps them on for a programmed number of ticks. After each window it turns every channel off, waits a settle delay, and hands a measurement request to an external ADC sequencer. Balancing resumes only after the sequencer acknowledges.

Thermal protection is enforced in three ways. At most two channels are open at once. Two open channels always share one thermal zone, which never contains neighbouring cells. A cell that has just bled is barred for a cool-down period, and the cool-down can be doubled from outside. A thermal policy block supplies the channel limit and the cool-down doubling. A shutdown block supplies the enable gate and a per-cell inhibit mask. All timers advance on a 1 ms tick input.

Top module: `cell_bleed_sched`

## Requirements
- R1: A cell is eligible only when its voltage minus the lowest cell voltage is strictly greater than `start_thr`, its `inhibit` bit is low, and it is not cooling down. Ineligible cells are never switched on.
- R2: Round-robin mode (`prio_mode`=0) serves the first eligible cell at or after a rotation pointer. The pointer starts at cell 1 (bit 0) after reset and then moves to just past the last cell served.
- R3: Priority mode (`prio_mode`=1) serves the eligible cell with the largest excess over the minimum. Ties go to the lowest bit index.
- R4: `conc_lim` of 2 or more allows two open channels; 0 or 1 allows one. If the limit drops during a window, only the lowest-indexed open channel stays on, in the same cycle.
- R5: Zone A is bits 0, 2, 4 (cells 1, 3, 5) and zone B is bits 1, 3, 5. A second channel comes only from the first channel's zone. In round-robin mode it is the next eligible same-zone cell in rotation after the first; in priority mode it is the same-zone cell with the largest excess.
- R6: A window keeps its channels on for `t_on` ticks. With a tick every cycle that is exactly `t_on` cycles, and `t_on`=0 gives one cycle.
- R7: After its window ends, a cell is barred until `t_cool` ticks have elapsed, or 2·`t_cool` while `cool_x2` is high. With a tick every cycle, and a cool-down longer than settle plus handshake, the sole eligible cell reopens `t_cool`+1 cycles (2·`t_cool`+1 when doubled) after it closed.
- R8: At the end of a window all outputs go off. After `t_settle` ticks `meas_req` rises and stays high, with all outputs off, until `meas_ack`. Selection resumes after the acknowledge.
- R9: When `bal_en` is low, `bal_out` and `meas_req` are zero in that same cycle. The scheduler returns to selection, and channels that were open start their cool-down.
- R10: During and right after reset, `bal_out` and `meas_req` are zero.
- R11: On-time, settle and cool-down counters advance only on cycles with `tick` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timer tick pulse (nominally 1 ms) |
| bal_en | input | 1 | Balance enable gate from the shutdown block |
| prio_mode | input | 1 | 0 round-robin, 1 largest-excess-first |
| cool_x2 | input | 1 | Doubles the cool-down period |
| conc_lim | input | 2 | Channel limit from the thermal block |
| inhibit | input | 6 | Per-cell inhibit, bit i = cell i+1 |
| cell_v | input | 96 | Cell voltages, 16 bits per cell, cell 1 in the low bits |
| start_thr | input | 16 | Minimum excess to start bleeding |
| t_on | input | 16 | On-time in ticks |
| t_cool | input | 16 | Cool-down in ticks |
| t_settle | input | 16 | Settle delay in ticks |
| meas_ack | input | 1 | Measurement done from the ADC sequencer |
| bal_out | output | 6 | Bleed switch enables, bit i = cell i+1 |
| meas_req | output | 1 | Measurement request to the ADC sequencer |

## Verification
The bench targets the selection edges. A cell exactly at threshold must stay off; a scheduler that tests with `>=` would bleed it. A priority tie must resolve to the lower index, and the rotation pointer must skip ineligible cells. In two-channel mode it checks that pairs never straddle zones and that the pair wraps correctly through the rotation. A scheduler that pairs neighbours or loses its pointer would show a wrong channel pattern in the window sequence. The bench also measures exact window, settle and reopen gaps. These catch off-by-one timers, a cool-down that ignores doubling, a request raised while a switch is still closed, and outputs that linger a cycle after the enable gate or the channel limit drops.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
  typedef enum logic [1:0] {
    ST_PICK   = 2'd0,
    ST_BLEED  = 2'd1,
    ST_SETTLE = 2'd2,
    ST_MEAS   = 2'd3
  } phase_t;
endpackage

// File: rtl/cbs_excess.sv
module cbs_excess #(
  parameter int NCELL = 6,
  parameter int VW    = 16
) (
  input  logic [NCELL*VW-1:0] cell_v,
  input  logic [VW-1:0]       start_thr,
  output logic [NCELL*VW-1:0] excess,
  output logic [NCELL-1:0]    over
);
  logic [VW-1:0] vmin;

  // lowest cell in the stack
  always_comb begin
    vmin = cell_v[VW-1:0];
    for (int i = 1; i < NCELL; i++) begin
      if (cell_v[i*VW +: VW] < vmin) vmin = cell_v[i*VW +: VW];
    end
  end

  // excess above the lowest cell, strict threshold compare (R1)
  always_comb begin
    for (int i = 0; i < NCELL; i++) begin
      excess[i*VW +: VW] = cell_v[i*VW +: VW] - vmin;
      over[i]            = (cell_v[i*VW +: VW] - vmin) > start_thr;
    end
  end
endmodule

// File: rtl/cbs_pick.sv
module cbs_pick #(
  parameter int NCELL = 6,
  parameter int VW    = 16,
  parameter int IW    = $clog2(NCELL)
) (
  input  logic [NCELL*VW-1:0] excess,
  input  logic [NCELL-1:0]    cand,
  input  logic                prio,
  input  logic                pair_ok,
  input  logic [IW-1:0]       ptr,
  output logic [NCELL-1:0]    sel,
  output logic [IW-1:0]       ptr_nxt
);
  always_comb begin
    int            c1;
    int            c2;
    int            idx;
    int            last;
    logic          f1;
    logic          f2;
    logic [VW-1:0] b1;
    logic [VW-1:0] b2;
    c1 = 0; c2 = 0; idx = 0; f1 = 1'b0; f2 = 1'b0; b1 = '0; b2 = '0;
    if (prio) begin
      // largest excess first, ties to the lowest index (R3)
      for (int i = 0; i < NCELL; i++) begin
        if (cand[i] && (!f1 || excess[i*VW +: VW] > b1)) begin
          c1 = i; b1 = excess[i*VW +: VW]; f1 = 1'b1;
        end
      end
      // partner: best cell of the same zone (R5)
      for (int i = 0; i < NCELL; i++) begin
        if (pair_ok && f1 && cand[i] && i != c1 && (i % 2) == (c1 % 2) &&
            (!f2 || excess[i*VW +: VW] > b2)) begin
          c2 = i; b2 = excess[i*VW +: VW]; f2 = 1'b1;
        end
      end
    end else begin
      // rotation from the pointer (R2)
      for (int k = 0; k < NCELL; k++) begin
        idx = (int'(ptr) + k) % NCELL;
        if (!f1 && cand[idx]) begin
          c1 = idx; f1 = 1'b1;
        end
      end
      // partner: next same-zone cell in rotation (R5)
      for (int k = 1; k < NCELL; k++) begin
        idx = (c1 + k) % NCELL;
        if (pair_ok && f1 && !f2 && cand[idx] && (idx % 2) == (c1 % 2)) begin
          c2 = idx; f2 = 1'b1;
        end
      end
    end
    sel = '0;
    if (f1) sel[c1] = 1'b1;
    if (f2) sel[c2] = 1'b1;
    last    = f2 ? c2 : c1;
    ptr_nxt = (last == NCELL - 1) ? '0 : IW'(last + 1);
  end
endmodule

// File: rtl/cbs_cool.sv
module cbs_cool #(
  parameter int NCELL = 6,
  parameter int TW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [NCELL-1:0] start,
  input  logic [TW-1:0]    t_cool,
  input  logic             cool_x2,
  output logic [NCELL-1:0] cooling
);
  logic [TW:0] limit;

  // effective cool-down, doubled on request (R7)
  always_comb limit = cool_x2 ? {t_cool, 1'b0} : {1'b0, t_cool};

  for (genvar g = 0; g < NCELL; g++) begin : g_cell
    logic        act_q, act_d;
    logic [TW:0] el_q, el_d;

    always_comb cooling[g] = act_q && (el_q < limit);

    always_comb begin
      act_d = act_q;
      el_d  = el_q;
      if (start[g]) begin
        act_d = 1'b1;
        el_d  = '0;
      end else if (act_q) begin
        if (!cooling[g])  act_d = 1'b0;
        else if (tick)    el_d  = el_q + 1'b1;  // R11 tick-gated
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act_q <= 1'b0;
        el_q  <= '0;
      end else begin
        act_q <= act_d;
        el_q  <= el_d;
      end
    end

    assert_cool_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (start[g] && t_cool != '0) |=> cooling[g]);
  end
endmodule

// File: rtl/cell_bleed_sched.sv
module cell_bleed_sched #(
  parameter int NCELL = 6,
  parameter int VW    = 16,
  parameter int TW    = 16,
  parameter int CW    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                bal_en,
  input  logic                prio_mode,
  input  logic                cool_x2,
  input  logic [CW-1:0]       conc_lim,
  input  logic [NCELL-1:0]    inhibit,
  input  logic [NCELL*VW-1:0] cell_v,
  input  logic [VW-1:0]       start_thr,
  input  logic [TW-1:0]       t_on,
  input  logic [TW-1:0]       t_cool,
  input  logic [TW-1:0]       t_settle,
  input  logic                meas_ack,
  output logic [NCELL-1:0]    bal_out,
  output logic                meas_req
);
  import cbs_pkg::*;
  localparam int IW = $clog2(NCELL);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  phase_t           st_q, st_d;
  logic [TW-1:0]    cnt_q, cnt_d;
  logic [NCELL-1:0] bal_q, bal_d;
  logic             meas_q, meas_d;
  logic [IW-1:0]    ptr_q, ptr_d;

  logic [NCELL*VW-1:0] excess;
  logic [NCELL-1:0]    over, cooling, cand, sel, cool_start;
  logic [IW-1:0]       ptr_nxt;
  logic                pair_ok, done;
  logic [TW-1:0]       lim;
  logic [TW:0]         step;

  assign pair_ok = conc_lim >= CW'(2);

  cbs_excess #(.NCELL(NCELL), .VW(VW)) u_excess (
    .cell_v(cell_v), .start_thr(start_thr), .excess(excess), .over(over));

  assign cand = over & ~inhibit & ~cooling;  // R1

  cbs_pick #(.NCELL(NCELL), .VW(VW), .IW(IW)) u_pick (
    .excess(excess), .cand(cand), .prio(prio_mode), .pair_ok(pair_ok),
    .ptr(ptr_q), .sel(sel), .ptr_nxt(ptr_nxt));

  cbs_cool #(.NCELL(NCELL), .TW(TW)) u_cool (
    .clk(clk), .rst_n(rst_ni), .tick(tick), .start(cool_start),
    .t_cool(t_cool), .cool_x2(cool_x2), .cooling(cooling));

  // phase timer (R6, R8, R11)
  always_comb begin
    lim  = (st_q == ST_BLEED) ? t_on : t_settle;
    step = {1'b0, cnt_q} + (TW+1)'(1);
    done = (lim == '0) || (tick && step >= {1'b0, lim});
  end

  // channels leaving a window start cooling (R7, R9)
  always_comb cool_start = (st_q == ST_BLEED && (!bal_en || done)) ? bal_q : '0;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    bal_d  = bal_q;
    meas_d = meas_q;
    ptr_d  = ptr_q;
    if (!bal_en) begin
      st_d   = ST_PICK;
      cnt_d  = '0;
      bal_d  = '0;
      meas_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_PICK: if (|sel) begin
          bal_d = sel;
          ptr_d = ptr_nxt;
          cnt_d = '0;
          st_d  = ST_BLEED;
        end
        ST_BLEED: if (done) begin
          bal_d = '0;
          cnt_d = '0;
          st_d  = ST_SETTLE;
        end else if (tick) cnt_d = cnt_q + TW'(1);
        ST_SETTLE: if (done) begin
          meas_d = 1'b1;
          cnt_d  = '0;
          st_d   = ST_MEAS;
        end else if (tick) cnt_d = cnt_q + TW'(1);
        ST_MEAS: if (meas_ack) begin
          meas_d = 1'b0;
          st_d   = ST_PICK;
        end
        default: st_d = ST_PICK;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_PICK;
      cnt_q  <= '0;
      bal_q  <= '0;
      meas_q <= 1'b0;
      ptr_q  <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      bal_q  <= bal_d;
      meas_q <= meas_d;
      ptr_q  <= ptr_d;
    end
  end

  // output gating: enable (R9) and live channel limit (R4)
  always_comb begin
    if (!bal_en)       bal_out = '0;
    else if (pair_ok)  bal_out = bal_q;
    else               bal_out = bal_q & (~bal_q + NCELL'(1));
    meas_req = meas_q && bal_en;
  end

  logic [NCELL-1:0] zone_a;
  always_comb for (int i = 0; i < NCELL; i++) zone_a[i] = (i % 2 == 0);

  assert_conc_limit_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    $countones(bal_out) <= (pair_ok ? 2 : 1));
  assert_one_zone_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    ((bal_out & zone_a) == '0) || ((bal_out & ~zone_a) == '0));
  assert_meas_quiet_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    meas_req |-> bal_out == '0);
  assert_meas_hold_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (meas_req && !meas_ack && bal_en) |=> (meas_req || !bal_en));
  assert_gate_clear_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    !bal_en |=> (bal_q == '0 && !meas_q));
endmodule

// File: tb/cell_bleed_sched_tb.sv
`timescale 1ns/1ps
module cell_bleed_sched_tb;
  localparam int N = 6, VW = 16, TW = 16;
  localparam int BASE = 3000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n, tick, bal_en, prio_mode, cool_x2, meas_ack;
  logic [1:0]    conc_lim;
  logic [N-1:0]  inhibit, bal_out;
  logic [N*VW-1:0] cell_v;
  logic [VW-1:0] start_thr;
  logic [TW-1:0] t_on, t_cool, t_settle;
  logic          meas_req;

  int checks = 0, errors = 0, cyc = 0;
  int off_cyc = 0, on_cyc = 0, on_seen = 0;
  logic slow_tick = 1'b0;
  int div = 0;

  cell_bleed_sched u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bal_en(bal_en), .prio_mode(prio_mode),
    .cool_x2(cool_x2), .conc_lim(conc_lim), .inhibit(inhibit), .cell_v(cell_v),
    .start_thr(start_thr), .t_on(t_on), .t_cool(t_cool), .t_settle(t_settle),
    .meas_ack(meas_ack), .bal_out(bal_out), .meas_req(meas_req));

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (slow_tick) begin
      tick = (div == 3);
      div  = (div + 1) % 4;
    end else tick = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_v(input int d0, input int d1, input int d2,
                       input int d3, input int d4, input int d5);
    cell_v = {VW'(BASE+d5), VW'(BASE+d4), VW'(BASE+d3),
              VW'(BASE+d2), VW'(BASE+d1), VW'(BASE+d0)};
  endtask

  task automatic hold_reset();
    rst_n = 1'b0; bal_en = 1'b1; prio_mode = 1'b0; cool_x2 = 1'b0;
    conc_lim = 2'd1; inhibit = '0; start_thr = 16'd10; t_on = 16'd3;
    t_cool = 16'd0; t_settle = 16'd2; meas_ack = 1'b0; slow_tick = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic release_reset();
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // one balance window followed by the measurement handshake
  task automatic run_window(input logic [N-1:0] exp, input int on_len,
                            input int settle_len, input int ack_delay, input string req);
    int n, m, w;
    w = 0;
    while (bal_out == '0 && w < 400) begin @(negedge clk); w++; end
    on_cyc = cyc;
    chk(bal_out == exp, req, "channels", int'(bal_out), int'(exp));
    n = 0;
    while (bal_out != '0 && n < 1000) begin n++; @(negedge clk); end
    off_cyc = cyc;
    on_seen = n;
    if (on_len >= 0) chk(n == on_len, "R6", "on cycles", n, on_len);
    m = 0;
    while (!meas_req && bal_out == '0 && m < 1000) begin m++; @(negedge clk); end
    if (settle_len >= 0) chk(m == settle_len, "R8", "settle cycles", m, settle_len);
    chk(meas_req && bal_out == '0, "R8", "request with outputs off", int'(meas_req), 1);
    for (int k = 0; k < ack_delay; k++) begin
      @(negedge clk);
      chk(meas_req && bal_out == '0, "R8", "request held until ack", int'(meas_req), 1);
    end
    meas_ack = 1'b1;
    @(negedge clk);
    meas_ack = 1'b0;
  endtask

  task automatic t_reset_state();  // R10
    set_v(50, 0, 50, 0, 0, 0);
    hold_reset();
    chk(bal_out == '0 && !meas_req, "R10", "outputs in reset", int'(bal_out), 0);
    release_reset();
    chk(bal_out == '0 && !meas_req, "R10", "outputs after release", int'(bal_out), 0);
  endtask

  task automatic t_gate_off();  // R9
    int bad;
    set_v(50, 0, 50, 0, 0, 0);
    hold_reset();
    bal_en = 1'b0;
    release_reset();
    bad = 0;
    for (int k = 0; k < 20; k++) begin
      if (bal_out != '0 || meas_req) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R9", "gate low keeps all off", bad, 0);
  endtask

  task automatic t_round_robin();  // R1 R2 R6 R8
    set_v(50, 0, 50, 50, 10, 0);   // bit4 exactly at threshold: not eligible (R1)
    hold_reset();
    release_reset();
    run_window(6'h01, 3, 2, 0, "R2");
    run_window(6'h04, 3, 2, 8, "R2");
    run_window(6'h08, 3, 2, 0, "R1");
    run_window(6'h01, 3, 2, 0, "R2");
  endtask

  task automatic t_priority_cool();  // R3 R7
    int bad;
    set_v(20, 60, 40, 0, 0, 60);
    hold_reset();
    prio_mode = 1'b1; t_cool = 16'd100;
    release_reset();
    run_window(6'h02, 3, 2, 0, "R3");  // tie 60/60 resolves to bit1
    run_window(6'h20, 3, 2, 0, "R3");
    run_window(6'h04, 3, 2, 0, "R3");
    run_window(6'h01, 3, 2, 0, "R3");
    bad = 0;
    for (int k = 0; k < 20; k++) begin
      if (bal_out != '0) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R7", "all cooling, nothing opens", bad, 0);
    run_window(6'h02, 3, 2, 0, "R7");
  endtask

  task automatic t_pair_rr();  // R5 R2
    set_v(50, 50, 50, 0, 50, 0);
    hold_reset();
    conc_lim = 2'd2;
    release_reset();
    run_window(6'h05, 3, 2, 0, "R5");
    run_window(6'h11, 3, 2, 0, "R5");
    run_window(6'h02, 3, 2, 0, "R5");
    run_window(6'h14, 3, 2, 0, "R5");
  endtask

  task automatic t_pair_prio_drop();  // R4 R5
    set_v(30, 80, 50, 70, 20, 0);
    hold_reset();
    prio_mode = 1'b1; conc_lim = 2'd2;
    release_reset();
    run_window(6'h0A, 3, 2, 0, "R5");
    t_on = 16'd20;
    while (bal_out == '0) @(negedge clk);
    chk(bal_out == 6'h0A, "R4", "two channels allowed", int'(bal_out), 'h0A);
    conc_lim = 2'd1;
    #1;
    chk(bal_out == 6'h02, "R4", "limit drop same cycle", int'(bal_out), 'h02);
    @(negedge clk);
    chk(bal_out == 6'h02, "R4", "limit drop held", int'(bal_out), 'h02);
  endtask

  task automatic t_inhibit();  // R1
    set_v(30, 80, 50, 70, 20, 0);
    hold_reset();
    prio_mode = 1'b1; inhibit = 6'h02;
    release_reset();
    run_window(6'h08, 3, 2, 0, "R1");
  endtask

  task automatic t_enable_drop();  // R9
    int bad;
    set_v(50, 0, 0, 0, 0, 0);
    hold_reset();
    t_on = 16'd20;
    release_reset();
    while (bal_out == '0) @(negedge clk);
    repeat (3) @(negedge clk);
    bal_en = 1'b0;
    #1;
    chk(bal_out == '0 && !meas_req, "R9", "gate drop same cycle", int'(bal_out), 0);
    bad = 0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (bal_out != '0 || meas_req) bad++;
    end
    chk(bad == 0, "R9", "stays off while gated", bad, 0);
  endtask

  task automatic t_cool_gap(input logic dbl);  // R7
    int gap, exp;
    set_v(50, 0, 0, 0, 0, 0);
    hold_reset();
    t_cool = 16'd10; cool_x2 = dbl;
    release_reset();
    run_window(6'h01, 3, 2, 0, "R7");
    gap = off_cyc;
    run_window(6'h01, 3, 2, 0, "R7");
    gap = on_cyc - gap;
    exp = (dbl ? 20 : 10) + 1;
    chk(gap == exp, "R7", "reopen gap", gap, exp);
  endtask

  task automatic t_slow_tick();  // R11
    set_v(50, 0, 0, 0, 0, 0);
    hold_reset();
    slow_tick = 1'b1;
    release_reset();
    run_window(6'h01, -1, -1, 0, "R11");
    chk(on_seen >= 9 && on_seen <= 12, "R11", "on cycles at quarter tick rate", on_seen, 12);
  endtask

  initial begin
    rst_n = 1'b0; tick = 1'b1; cell_v = '0;
    t_reset_state();
    t_gate_off();
    t_round_robin();
    t_priority_cool();
    t_pair_rr();
    t_pair_prio_drop();
    t_inhibit();
    t_enable_drop();
    t_cool_gap(1'b0);
    t_cool_gap(1'b1);
    t_slow_tick();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R8 watchdog: got %0d cycles expected completion", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule